// File: doc/BRIEF.md
# Dual-Channel PCM Slot Port with Per-Channel Mute

This block is the digital side of a two-channel voice port. A frame sync marks the start of a frame, and two 8-bit time slots follow back to back on the serial lines: the first slot (B1) and then the second (B2). All timing runs on the bit clock. On the transmit side the block shifts each channel's parallel sample onto the serial output, most significant bit first. It drives a separate output enable that the pad ring uses as the tristate control. On the receive side it collects the serial input bits of each slot and hands one parallel sample per channel to the decoder side, with a one-cycle valid strobe.

A one-register port, synchronous to the bit clock, holds a mute bit for each channel and a slot-swap bit. A muted channel releases the serial output for its whole slot and reports a fixed silence code instead of the received data. The other channel carries on as before. The swap bit chooses which physical slot belongs to which channel, and the mute bits follow that choice. Register writes land in a pending copy. The copy used by the slot logic is updated only at frame sync, together with the transmit samples, so no slot is ever half muted or half swapped.

Top module: `pcm_dual_slot`

## Requirements
- R1: When `fs` is high at a rising edge of `bclk`, the next 16 bit periods carry slot B1 (bits 0..7) and then slot B2 (bits 8..15). Each bit is launched by a rising edge, most significant bit first.
- R2: Outside those 16 bit periods, and from reset until the first frame sync, `dx_oe` is low.
- R3: With the swap bit at 0, channel 0 uses B1 and channel 1 uses B2, in both directions. With the swap bit at 1, channel 1 uses B1 and channel 0 uses B2. Only one channel's valid strobe is high on any cycle.
- R4: While a channel is muted, `dx_oe` is low for all 8 bit periods of that channel's slot. The other channel's slot is still driven with its sample.
- R5: When a muted channel's sample is delivered, it equals the silence code (parameter `SILENCE`, default 8'hD5), whatever data was on `dr`. An unmuted channel delivers the bits received in its slot.
- R6: `dr` is sampled on the falling edge of `bclk`. The first bit sampled in a slot is the sample's most significant bit. A slot's sample appears on its channel's `rx_ch*` output, with a one-cycle `rx_vld` pulse, right after the rising edge that ends the slot. Bits on `dr` outside the two slots have no effect.
- R7: The configuration register is at `cpu_addr` = 4. Bit 5 mutes channel 0, bit 4 mutes channel 1, and bit 0 is the swap bit. All other bits read as 0. A read of address 4 returns the last value written. Any other address reads 0, and writes to it change nothing.
- R8: The mute and swap settings and both transmit samples are captured at the rising edge where `fs` is seen high. A write or an input change during a frame affects only later frames.
- R9: After reset, `dx_oe` is low, both `rx_vld` bits are low, both `rx_ch*` outputs hold the silence code, and the register reads 0.
- R10: A frame sync seen on the edge that ends slot B2 starts a new frame at once. The B2 sample of the ending frame is still delivered under that frame's settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs | input | 1 | Frame sync, sampled on the rising edge |
| dr | input | 1 | Serial receive data, sampled on the falling edge |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Transmit output enable (low means high impedance at the pad) |
| tx_ch0 | input | SW | Transmit sample for channel 0 |
| tx_ch1 | input | SW | Transmit sample for channel 1 |
| rx_ch0 | output | SW | Received sample for channel 0 |
| rx_ch1 | output | SW | Received sample for channel 1 |
| rx_vld | output | 2 | One-cycle valid strobe per channel (bit 0 is channel 0) |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | AW | Register address |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data (combinational) |

## Verification
Two events can land on the same rising edge. One is delivery of the closing B2 sample. The other is the new frame's capture of mute, swap and transmit samples. The bench provokes this by raising frame sync during the last bit of a frame whose pending settings were changed by a mid-frame write. The scoreboard then expects the closing B2 sample under the old mute and swap state, and expects the new frame's serial output and received samples under the new state. The bench also changes the transmit inputs during that same frame, so a sample taken at the wrong edge would show up on `dx`.

// File: rtl/pcm_dual_slot.sv
module pcm_dual_slot #(
  parameter int SW = 8,
  parameter int AW = 3,
  parameter int DW = 8,
  parameter logic [AW-1:0] CFG_ADDR = 3'd4,
  parameter int MUTE0_BIT = 5,
  parameter int MUTE1_BIT = 4,
  parameter int SWAP_BIT = 0,
  parameter logic [SW-1:0] SILENCE = 8'hD5
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          fs,
  input  logic          dr,
  output logic          dx,
  output logic          dx_oe,
  input  logic [SW-1:0] tx_ch0,
  input  logic [SW-1:0] tx_ch1,
  output logic [SW-1:0] rx_ch0,
  output logic [SW-1:0] rx_ch1,
  output logic [1:0]    rx_vld,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata
);
  localparam int CW = $clog2(2*SW+1);
  localparam logic [CW-1:0] IDLE    = CW'(2*SW);
  localparam logic [CW-1:0] B2_FIRST = CW'(SW);
  localparam logic [CW-1:0] B1_LAST = CW'(SW-1);
  localparam logic [CW-1:0] B2_LAST = CW'(2*SW-1);

  logic [CW-1:0] cnt;
  logic [1:0]    mute_pend, mute_act;
  logic          swap_pend, swap_act;
  logic [SW-1:0] tx0_q, tx1_q, rx_sh, rx_q0, rx_q1;
  logic          dr_q;

  wire            in_slot = (cnt != IDLE);
  wire            in_b2   = in_slot && (cnt >= B2_FIRST);
  wire            slot_ch = in_b2 ^ swap_act;
  wire [CW-1:0]   bpos    = in_b2 ? cnt - B2_FIRST : cnt;
  wire [SW-1:0]   tx_sel  = slot_ch ? tx1_q : tx0_q;
  wire [SW-1:0]   tx_shl  = tx_sel << bpos;
  wire [SW-1:0]   rx_byte = {rx_sh[SW-2:0], dr_q};
  wire            slot_end = (cnt == B1_LAST) || (cnt == B2_LAST);

  assign dx_oe  = in_slot && !mute_act[slot_ch];
  assign dx     = dx_oe && tx_shl[SW-1];
  assign rx_ch0 = rx_q0;
  assign rx_ch1 = rx_q1;

  always_ff @(posedge bclk or negedge rst_n)
    if (!rst_n) begin
      mute_pend <= '0;
      swap_pend <= 1'b0;
    end else if (cpu_we && cpu_addr == CFG_ADDR) begin
      mute_pend <= {cpu_wdata[MUTE1_BIT], cpu_wdata[MUTE0_BIT]};
      swap_pend <= cpu_wdata[SWAP_BIT];
    end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == CFG_ADDR) begin
      cpu_rdata[MUTE0_BIT] = mute_pend[0];
      cpu_rdata[MUTE1_BIT] = mute_pend[1];
      cpu_rdata[SWAP_BIT]  = swap_pend;
    end
  end

  always_ff @(posedge bclk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= IDLE;
      mute_act <= '0;
      swap_act <= 1'b0;
      tx0_q    <= '0;
      tx1_q    <= '0;
    end else if (fs) begin
      cnt      <= '0;
      mute_act <= mute_pend;
      swap_act <= swap_pend;
      tx0_q    <= tx_ch0;
      tx1_q    <= tx_ch1;
    end else if (in_slot) begin
      cnt <= cnt + 1'b1;
    end

  always_ff @(negedge bclk or negedge rst_n)
    if (!rst_n) dr_q <= 1'b0;
    else        dr_q <= dr;

  always_ff @(posedge bclk or negedge rst_n)
    if (!rst_n) begin
      rx_sh  <= '0;
      rx_q0  <= SILENCE;
      rx_q1  <= SILENCE;
      rx_vld <= '0;
    end else begin
      rx_vld <= '0;
      if (in_slot) begin
        rx_sh <= rx_byte;
        if (slot_end) begin
          rx_vld[slot_ch] <= 1'b1;
          if (slot_ch) rx_q1 <= mute_act[1] ? SILENCE : rx_byte;
          else         rx_q0 <= mute_act[0] ? SILENCE : rx_byte;
        end
      end
    end
endmodule

// File: rtl/pcm_dual_slot_chk.sv
module pcm_dual_slot_chk #(
  parameter int SW = 8,
  parameter logic [SW-1:0] SILENCE = 8'hD5
) (
  input logic          bclk,
  input logic          rst_n,
  input logic          fs,
  input logic          dx_oe,
  input logic [1:0]    rx_vld,
  input logic [SW-1:0] rx_ch0,
  input logic [SW-1:0] rx_ch1,
  input logic [1:0]    mute_act,
  input logic          swap_act
);
  localparam int CW = $clog2(2*SW+1);
  localparam logic [CW-1:0] IDLE = CW'(2*SW);

  logic [CW-1:0] pos;
  always_ff @(posedge bclk or negedge rst_n)
    if (!rst_n)          pos <= IDLE;
    else if (fs)         pos <= '0;
    else if (pos != IDLE) pos <= pos + 1'b1;

  wire own_ch = (pos >= CW'(SW)) ^ swap_act;

  a_r2_quiet_outside: assert property (@(posedge bclk) disable iff (!rst_n)
    (pos == IDLE) |-> !dx_oe);
  a_r4_muted_slot_released: assert property (@(posedge bclk) disable iff (!rst_n)
    (pos != IDLE && mute_act[own_ch]) |-> !dx_oe);
  a_r3_one_strobe: assert property (@(posedge bclk) disable iff (!rst_n)
    $onehot0(rx_vld));
  a_r6_pulse0: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_vld[0] |=> !rx_vld[0]);
  a_r6_pulse1: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_vld[1] |=> !rx_vld[1]);
  a_r6_strobe_timing: assert property (@(posedge bclk) disable iff (!rst_n)
    (rx_vld != 2'b00) |-> (pos == CW'(SW) || pos == IDLE || pos == '0));
  a_r5_silence0: assert property (@(posedge bclk) disable iff (!rst_n)
    (rx_vld[0] && $past(mute_act[0])) |-> rx_ch0 == SILENCE);
  a_r5_silence1: assert property (@(posedge bclk) disable iff (!rst_n)
    (rx_vld[1] && $past(mute_act[1])) |-> rx_ch1 == SILENCE);
  a_r8_cfg_frozen: assert property (@(posedge bclk) disable iff (!rst_n)
    !fs |=> ($stable(mute_act) && $stable(swap_act)));
endmodule

bind pcm_dual_slot pcm_dual_slot_chk #(.SW(SW), .SILENCE(SILENCE)) u_chk (
  .bclk(bclk), .rst_n(rst_n), .fs(fs), .dx_oe(dx_oe), .rx_vld(rx_vld),
  .rx_ch0(rx_ch0), .rx_ch1(rx_ch1), .mute_act(mute_act), .swap_act(swap_act)
);

// File: tb/pcm_dual_slot_bench.sv
module pcm_dual_slot_bench;
  localparam int TCLK = 10;
  localparam logic [7:0] SIL = 8'hD5;

  logic bclk = 1'b0, rst_n = 1'b0, fs = 1'b0, dr = 1'b0, cpu_we = 1'b0;
  logic [7:0] tx_ch0 = '0, tx_ch1 = '0, cpu_wdata = '0, cpu_rdata, rx_ch0, rx_ch1;
  logic [2:0] cpu_addr = 3'd4;
  logic [1:0] rx_vld;
  logic dx, dx_oe;

  always #(TCLK/2) bclk = ~bclk;

  pcm_dual_slot #(.SILENCE(SIL)) u_pcm_dual_slot (
    .bclk(bclk), .rst_n(rst_n), .fs(fs), .dr(dr), .dx(dx), .dx_oe(dx_oe),
    .tx_ch0(tx_ch0), .tx_ch1(tx_ch1), .rx_ch0(rx_ch0), .rx_ch1(rx_ch1),
    .rx_vld(rx_vld), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

  int n_chk = 0, n_fail = 0;
  logic [7:0] q0[$], q1[$];
  logic [1:0] pend_mute = '0;
  logic pend_swap = 1'b0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic step;
    @(posedge bclk); #1;
  endtask

  always @(negedge bclk) if (rst_n) begin
    if (rx_vld[0]) begin
      if (q0.size() == 0) check("R6 unexpected ch0 strobe", 8'h1, 8'h0);
      else check("R5/R6 ch0 sample", rx_ch0, q0.pop_front());
    end
    if (rx_vld[1]) begin
      if (q1.size() == 0) check("R6 unexpected ch1 strobe", 8'h1, 8'h0);
      else check("R5/R6 ch1 sample", rx_ch1, q1.pop_front());
    end
  end

  task automatic cpu_write(logic [2:0] a, logic [7:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    step;
    cpu_we = 1'b0; cpu_addr = 3'd4;
    if (a == 3'd4) begin pend_mute = {d[4], d[5]}; pend_swap = d[0]; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      dr = i[0] ^ i[1];
      @(negedge bclk);
      check("R2 no drive outside slots", {7'd0, dx_oe}, 8'h0);
      step;
    end
  endtask

  // one frame; mid_wr: write cfg word wr_d during bit 3 and disturb tx inputs (R8)
  // chain: raise fs during the last bit for a back-to-back frame (R10)
  task automatic frame(logic [7:0] t0, logic [7:0] t1, logic [7:0] b1, logic [7:0] b2,
                       bit mid_wr, logic [7:0] wr_d, bit chain);
    logic [1:0] m;
    logic sw, ch, oe_exp, bit_exp;
    logic [7:0] tsel;
    tx_ch0 = t0; tx_ch1 = t1; fs = 1'b1;
    step;
    fs = 1'b0;
    m = pend_mute; sw = pend_swap;
    if (sw) begin
      q1.push_back(m[1] ? SIL : b1); q0.push_back(m[0] ? SIL : b2);
    end else begin
      q0.push_back(m[0] ? SIL : b1); q1.push_back(m[1] ? SIL : b2);
    end
    for (int b = 0; b < 16; b++) begin
      dr = (b < 8) ? b1[7-b] : b2[15-b];
      if (mid_wr && b == 3) begin
        cpu_we = 1'b1; cpu_wdata = wr_d;
        tx_ch0 = ~t0; tx_ch1 = ~t1;
      end
      if (mid_wr && b == 4) begin
        cpu_we = 1'b0; pend_mute = {wr_d[4], wr_d[5]}; pend_swap = wr_d[0];
      end
      ch = (b >= 8) ^ sw;
      tsel = ch ? t1 : t0;
      oe_exp = !m[ch];
      bit_exp = tsel[7 - (b % 8)];
      @(negedge bclk);
      check("R1/R3/R4 dx_oe per slot", {7'd0, dx_oe}, {7'd0, oe_exp});
      if (oe_exp) check("R1/R3/R8 dx bit msb first", {7'd0, dx}, {7'd0, bit_exp});
      if (chain && b == 15) begin #1; return; end
      step;
    end
  endtask

  initial begin
    #(TCLK * 100000);
    check("watchdog expired", 8'h1, 8'h0);
    report();
  end

  initial begin
    repeat (3) @(posedge bclk);
    #1;
    check("R9 reset dx_oe", {7'd0, dx_oe}, 8'h0);
    check("R9 reset rx_vld", {6'd0, rx_vld}, 8'h0);
    check("R9 reset rx_ch0", rx_ch0, SIL);
    check("R9 reset rx_ch1", rx_ch1, SIL);
    check("R9 reset register", cpu_rdata, 8'h00);
    rst_n = 1'b1;
    step;
    idle(4);
    // R1 R3 R6: plain frame, no swap
    frame(8'hA5, 8'h3C, 8'h96, 8'h1E, 1'b0, 8'h00, 1'b0);
    idle(6);
    // R4 R5 R7: mute channel 0
    cpu_write(3'd4, 8'h20);
    check("R7 readback mute ch0", cpu_rdata, 8'h20);
    frame(8'h5A, 8'hC3, 8'h71, 8'hE8, 1'b0, 8'h00, 1'b0);
    idle(3);
    // R3 R4 R5: swap with channel 1 muted
    cpu_write(3'd4, 8'hFF);
    check("R7 readback unused bits zero", cpu_rdata, 8'h31);
    cpu_write(3'd4, 8'h11);
    check("R7 readback swap+mute ch1", cpu_rdata, 8'h11);
    frame(8'h0F, 8'hF0, 8'h4B, 8'hB4, 1'b0, 8'h00, 1'b0);
    idle(2);
    // R7: other address ignored
    cpu_write(3'd3, 8'hFF);
    cpu_addr = 3'd3; #1;
    check("R7 other address reads zero", cpu_rdata, 8'h00);
    cpu_addr = 3'd4; #1;
    check("R7 config unchanged by other address", cpu_rdata, 8'h11);
    frame(8'h81, 8'h7E, 8'h12, 8'h34, 1'b0, 8'h00, 1'b0);
    idle(2);
    // R8 R10: mid-frame write, then back-to-back frame under new settings
    cpu_write(3'd4, 8'h00);
    frame(8'hC6, 8'h39, 8'hAA, 8'h55, 1'b1, 8'h21, 1'b1);
    frame(8'h66, 8'h99, 8'hCD, 8'h02, 1'b0, 8'h00, 1'b1);
    frame(8'h13, 8'hEC, 8'h3F, 8'hD0, 1'b0, 8'h00, 1'b0);
    idle(4);
    check("R6 ch0 queue drained", 8'(q0.size()), 8'h0);
    check("R6 ch1 queue drained", 8'(q1.size()), 8'h0);
    report();
  end
endmodule